// File: doc/BRIEF.md
# Packed FIFO Data-Window Bus Port

This block sits between a 32-bit host slave port and the per-channel FIFOs of a dual-channel serial controller. It lets software load a transmit FIFO or unload a receive FIFO one DWORD at a time instead of one byte at a time. A DWORD write to a transmit window turns into up to four single-byte pushes. A DWORD read from a receive window turns into up to two pops. Each popped data byte comes back next to the line-status byte that was stored with it, so data and its error flags arrive in one bus word.

Each channel has its own transmit window and its own receive window. The address bits below the window granularity are ignored, so a linear burst over a window keeps pushing into, or popping from, the same FIFO. The host side uses a valid/ready request. When `hst_valid` and `hst_ready` are both high at a clock edge, the request is accepted. `hst_ready` then stays low until the single-cycle `hst_done` pulse, and `hst_rdata` is valid during that pulse.

The FIFO sides follow valid/ready transfer rules, with these back-pressure rules:
- A receive entry is consumed only in a cycle where `rx_valid` and `rx_ready` are both high.
- The transmit side never stalls the block. A byte presented while `tx_ready` is low is discarded, and the discard is recorded.

Top module: `fifo_window_port`

## Requirements
- R1: Address bit 8 set and bit 7 clear selects a transmit window for writes. Address bits 9 and up select the channel, so offset 0x100 is channel 0 and 0x300 is channel 1. Bits 6:0 are ignored.
- R2: A write to a transmit window pushes the enabled byte lanes of `hst_wdata`, and only those. Lane 0 (bits 7:0) goes first, then lanes 1, 2 and 3 in ascending order, one byte per cycle on the selected channel. At most one `tx_valid` bit is high in any cycle.
- R3: A byte presented while that channel's `tx_ready` is low is dropped. It sets that channel's bit in `tx_ovf`, which stays set until reset.
- R4: With address bits 8 and 7 both set, a read selects that channel's receive window (0x180 for channel 0, 0x380 for channel 1). A full read returns status n+0 in bits 7:0, data n+0 in 15:8, status n+1 in 23:16 and data n+1 in 31:24. Entry n+0 is popped before entry n+1.
- R5: An entry is popped only for a halfword whose two byte enables are both set. A halfword with exactly one enable returns the current head entry without popping it. A halfword with no enables returns zero and does not pop.
- R6: A halfword slot that finds its receive FIFO empty returns zero for both data and status (data-ready bit 0 clear) and does not pop. `rx_ready` is never high while the matching `rx_valid` is low.
- R7: The following are unmapped: an address with bit 8 clear, a channel number at or above NCH, a read of a transmit window, and a write of a receive window. An unmapped access completes with `hst_rdata` = 0 and neither pushes nor pops.
- R8: Each accepted request produces exactly one single-cycle `hst_done`, and `hst_ready` is low from acceptance until that pulse ends. While the block is idle, it drives no `tx_valid` and no `rx_ready`.
- R9: After reset, `hst_ready` = 1, `hst_done` = 0, `tx_ovf` = 0, `tx_valid` = 0 and `rx_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host request present |
| hst_ready | output | 1 | Block idle and able to accept a request |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 9+CH_W | Byte address of the access |
| hst_be | input | 4 | Byte-lane enables |
| hst_wdata | input | 32 | Write data |
| hst_done | output | 1 | Single-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid with `hst_done` |
| tx_valid | output | NCH | Per-channel transmit push request |
| tx_ready | input | NCH | Per-channel transmit FIFO not full |
| tx_data | output | 8 | Byte being pushed |
| tx_ovf | output | NCH | Sticky per-channel dropped-push flag |
| rx_valid | input | NCH | Per-channel receive FIFO not empty |
| rx_ready | output | NCH | Per-channel pop strobe |
| rx_data | input | 8*NCH | Head data byte of each receive FIFO |
| rx_stat | input | 8*NCH | Head line-status byte of each receive FIFO |

## Verification
The bench builds the block with NCH = 2, which exercises the channel-select bit and all four windows. Its behavioural transmit FIFOs hold 64 bytes, so sixteen full writes reach the full state and a seventeenth write exercises the drop path and the sticky flag. The receive models are preloaded with short, uneven queues, so single-entry tails, empty slots, partial-lane peeks and burst offsets inside a window all occur within a handful of reads.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX, ST_DONE} fwp_state_t;
  typedef enum logic [1:0] {WIN_NONE, WIN_TX, WIN_RX} fwp_win_t;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int WIN_LSB = 9;
endpackage

// File: rtl/fwp_decode.sv
module fwp_decode
  import fwp_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic [WIN_LSB+CH_W-1:0] addr,
  input  logic                    write,
  output fwp_win_t                kind,
  output logic [CH_W-1:0]         ch
);
  logic in_range;

  assign ch       = addr[WIN_LSB+CH_W-1:WIN_LSB];
  assign in_range = (int'(ch) < NCH);

  always_comb begin
    kind = WIN_NONE;
    if (addr[8] && in_range) begin
      if (addr[7] && !write)      kind = WIN_RX;
      else if (!addr[7] && write) kind = WIN_TX;
    end
  end
endmodule

// File: rtl/fwp_tx_lanes.sv
module fwp_tx_lanes
  import fwp_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [1:0]        lane,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CH_W-1:0]   ch,
  input  logic [NCH-1:0]    tx_ready,
  output logic [NCH-1:0]    tx_valid,
  output logic [7:0]        tx_data,
  output logic [NCH-1:0]    tx_ovf
);
  logic lane_on;

  assign lane_on = active && be[lane];
  assign tx_data = wdata[8*lane +: 8];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign tx_valid[i] = lane_on && (ch == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         tx_ovf[i] <= 1'b0;
      else if (tx_valid[i] && !tx_ready[i]) tx_ovf[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/fwp_rx_slots.sv
module fwp_rx_slots
  import fwp_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic             active,
  input  logic             slot,
  input  logic [LANES-1:0] be,
  input  logic [CH_W-1:0]  ch,
  input  logic [NCH-1:0]   rx_valid,
  input  logic [8*NCH-1:0] rx_data,
  input  logic [8*NCH-1:0] rx_stat,
  output logic [NCH-1:0]   rx_ready,
  output logic [15:0]      word
);
  logic [1:0] pair;
  logic       head_ok;
  logic       pop;

  assign pair    = slot ? be[3:2] : be[1:0];
  assign head_ok = rx_valid[ch];
  assign pop     = active && (&pair) && head_ok;
  assign word    = (active && (|pair) && head_ok)
                   ? {rx_data[8*ch +: 8], rx_stat[8*ch +: 8]} : 16'h0000;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rx_ready[i] = pop && (ch == CH_W'(i));
  end
endmodule

// File: rtl/fifo_window_port.sv
module fifo_window_port
  import fwp_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = WIN_LSB + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [3:0]        hst_be,
  input  logic [31:0]       hst_wdata,
  output logic              hst_done,
  output logic [31:0]       hst_rdata,
  output logic [NCH-1:0]    tx_valid,
  input  logic [NCH-1:0]    tx_ready,
  output logic [7:0]        tx_data,
  output logic [NCH-1:0]    tx_ovf,
  input  logic [NCH-1:0]    rx_valid,
  output logic [NCH-1:0]    rx_ready,
  input  logic [8*NCH-1:0]  rx_data,
  input  logic [8*NCH-1:0]  rx_stat
);
  fwp_state_t        st;
  logic [1:0]        step;
  logic [CH_W-1:0]   ch_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  fwp_win_t          dec_kind;
  logic [CH_W-1:0]   dec_ch;
  logic [15:0]       slot_word;

  fwp_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .addr(hst_addr), .write(hst_write), .kind(dec_kind), .ch(dec_ch)
  );

  fwp_tx_lanes #(.NCH(NCH), .CH_W(CH_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(st == ST_TX), .lane(step),
    .be(be_q), .wdata(wd_q), .ch(ch_q), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ovf(tx_ovf)
  );

  fwp_rx_slots #(.NCH(NCH), .CH_W(CH_W)) u_rx (
    .active(st == ST_RX), .slot(step[0]), .be(be_q), .ch(ch_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_stat(rx_stat),
    .rx_ready(rx_ready), .word(slot_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      step <= '0;
      ch_q <= '0;
      be_q <= '0;
      wd_q <= '0;
      rd_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (hst_valid) begin
          ch_q <= dec_ch;
          be_q <= hst_be;
          wd_q <= hst_wdata;
          rd_q <= '0;
          step <= '0;
          case (dec_kind)
            WIN_TX:  st <= ST_TX;
            WIN_RX:  st <= ST_RX;
            default: st <= ST_DONE;
          endcase
        end
        ST_TX: begin
          step <= step + 2'd1;
          if (step == 2'd3) st <= ST_DONE;
        end
        ST_RX: begin
          if (step[0]) rd_q[31:16] <= slot_word;
          else         rd_q[15:0]  <= slot_word;
          step <= step + 2'd1;
          if (step[0]) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign hst_ready = (st == ST_IDLE);
  assign hst_done  = (st == ST_DONE);
  assign hst_rdata = rd_q;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hst_valid,
  input logic           hst_ready,
  input logic           hst_done,
  input logic [NCH-1:0] tx_valid,
  input logic [NCH-1:0] tx_ovf,
  input logic [NCH-1:0] rx_valid,
  input logic [NCH-1:0] rx_ready
);
  p_single_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid));

  p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tx_ovf & $past(tx_ovf)) == $past(tx_ovf)));

  p_single_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ready));

  p_pop_with_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready & ~rx_valid) == '0);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && hst_ready) |=> !hst_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_done |=> !hst_done);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ready |-> (tx_valid == '0 && rx_ready == '0 && !hst_done));
endmodule

bind fifo_window_port fwp_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
  .hst_done(hst_done), .tx_valid(tx_valid), .tx_ovf(tx_ovf),
  .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/sim_fifo_window_port.sv
module sim_fifo_window_port;
  localparam int NCH = 2;
  localparam int TXD = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0;
  logic [9:0]  hst_addr = '0;
  logic [3:0]  hst_be = '0;
  logic [31:0] hst_wdata = '0;
  logic        hst_ready, hst_done;
  logic [31:0] hst_rdata;
  logic [NCH-1:0] tx_valid, tx_ready, tx_ovf, rx_valid, rx_ready;
  logic [7:0]  tx_data;
  logic [8*NCH-1:0] rx_data, rx_stat;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [7:0] txm [NCH][80];
  int         txc [NCH];
  logic       tx_clr = 1'b0;
  logic [7:0] rxd [NCH][16];
  logic [7:0] rxs [NCH][16];
  int         rx_tail [NCH];
  int         rx_head [NCH];

  always #10 clk = ~clk;

  fifo_window_port #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
    .hst_write(hst_write), .hst_addr(hst_addr), .hst_be(hst_be),
    .hst_wdata(hst_wdata), .hst_done(hst_done), .hst_rdata(hst_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_ovf(tx_ovf), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_stat(rx_stat)
  );

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (tx_clr) txc[c] <= 0;
      else if (tx_valid[c] && tx_ready[c]) begin
        txm[c][txc[c]] <= tx_data;
        txc[c] <= txc[c] + 1;
      end
      if (!rst_n) rx_head[c] <= 0;
      else if (rx_ready[c] && rx_valid[c]) rx_head[c] <= rx_head[c] + 1;
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tx_ready[c] = (txc[c] < TXD);
      rx_valid[c] = (rx_head[c] < rx_tail[c]);
      rx_data[8*c +: 8] = rxd[c][rx_head[c]];
      rx_stat[8*c +: 8] = rxs[c][rx_head[c]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [9:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = wr; hst_addr = a; hst_be = be; hst_wdata = wd;
    @(negedge clk);
    hst_valid = 1'b0;
    while (!hst_done) @(negedge clk);
    rd = hst_rdata;
    @(negedge clk);
  endtask

  // {addr[63:48], be[47:44], pad, expected rdata[31:0]}
  localparam logic [63:0] RDV [7] = '{
    {16'h0180, 4'hF, 12'h0, 32'hA203A101},
    {16'h01BC, 4'hF, 12'h0, 32'hA411A301},
    {16'h0380, 4'h3, 12'h0, 32'h0000B121},
    {16'h0180, 4'h1, 12'h0, 32'h0000A501},
    {16'h0180, 4'hF, 12'h0, 32'h0000A501},
    {16'h0180, 4'hF, 12'h0, 32'h00000000},
    {16'h0384, 4'hC, 12'h0, 32'hB2010000}
  };

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int c = 0; c < NCH; c++) begin txc[c] = 0; rx_tail[c] = 0; end
    rxd[0][0] = 8'hA1; rxs[0][0] = 8'h01;
    rxd[0][1] = 8'hA2; rxs[0][1] = 8'h03;
    rxd[0][2] = 8'hA3; rxs[0][2] = 8'h01;
    rxd[0][3] = 8'hA4; rxs[0][3] = 8'h11;
    rxd[0][4] = 8'hA5; rxs[0][4] = 8'h01;
    rxd[1][0] = 8'hB1; rxs[1][0] = 8'h21;
    rxd[1][1] = 8'hB2; rxs[1][1] = 8'h01;
    for (int k = 5; k < 16; k++) begin
      rxd[0][k] = 8'h00; rxs[0][k] = 8'h00; rxd[1][k] = 8'h00; rxs[1][k] = 8'h00;
    end
    rx_tail[0] = 5; rx_tail[1] = 2;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 hst_ready", {31'd0, hst_ready}, 32'd1);
    check("R9 hst_done", {31'd0, hst_done}, 32'd0);
    check("R9 tx_ovf", {30'd0, tx_ovf}, 32'd0);
    check("R9 tx_valid/rx_ready", {28'd0, tx_valid, rx_ready}, 32'd0);
    rst_n = 1'b1;

    // R2 full-word push order, R1 channel 0 window
    access(1'b1, 10'h100, 4'hF, 32'h44332211, r);
    check("R2 ch0 count", txc[0], 32'd4);
    check("R2 lane order", {txm[0][0], txm[0][1], txm[0][2], txm[0][3]}, 32'h11223344);
    // R2 sparse lanes, R1 channel 1 window
    access(1'b1, 10'h304, 4'h5, 32'hDDCCBBAA, r);
    check("R2 ch1 sparse count", txc[1], 32'd2);
    check("R2 ch1 sparse bytes", {16'd0, txm[1][0], txm[1][1]}, 32'h0000AACC);
    check("R1 ch0 untouched", txc[0], 32'd4);
    // R1 low offset bits ignored
    access(1'b1, 10'h17C, 4'h8, 32'h55000000, r);
    check("R1 offset push", {txc[0], 24'd0} | {24'd0, txm[0][4]}, {32'd5, 24'd0} | 32'h55);

    // R7 unmapped accesses
    access(1'b1, 10'h0C0, 4'hF, 32'hFFFFFFFF, r);
    access(1'b1, 10'h180, 4'hF, 32'hFFFFFFFF, r);
    check("R7 no push", txc[0] + txc[1], 32'd7);
    access(1'b0, 10'h040, 4'hF, 32'h0, r);
    check("R7 rdata zero", r, 32'h0);
    access(1'b0, 10'h100, 4'hF, 32'h0, r);
    check("R7 tx window read zero", r, 32'h0);
    check("R7 no pop", rx_head[0] + rx_head[1], 32'd0);

    // R4 R5 R6 table of receive-window reads
    for (int i = 0; i < 7; i++) begin
      access(1'b0, RDV[i][57:48], RDV[i][47:44], 32'h0, r);
      check($sformatf("R4/R5/R6 table entry %0d", i), r, RDV[i][31:0]);
    end
    check("R5 R6 ch0 pops", rx_head[0], 32'd5);
    check("R6 ch1 pops", rx_head[1], 32'd2);

    // R3 fill to full then overflow
    @(negedge clk); tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
    for (int w = 0; w < 16; w++) access(1'b1, 10'h100, 4'hF, 32'h03020100 + w, r);
    check("R3 full count", txc[0], 32'd64);
    check("R3 no ovf yet", {30'd0, tx_ovf}, 32'd0);
    access(1'b1, 10'h100, 4'hF, 32'h99999999, r);
    check("R3 dropped", txc[0], 32'd64);
    check("R3 ovf ch0 only", {30'd0, tx_ovf}, 32'd1);
    @(negedge clk); tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
    access(1'b1, 10'h100, 4'hF, 32'h12345678, r);
    check("R3 push after drain", txc[0], 32'd4);
    check("R3 ovf sticky", {30'd0, tx_ovf}, 32'd1);

    // R8 done is one cycle and ready returns
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b0; hst_addr = 10'h000; hst_be = 4'hF;
    @(negedge clk);
    hst_valid = 1'b0;
    check("R8 busy after accept", {31'd0, hst_ready}, 32'd0);
    check("R8 done pulse", {31'd0, hst_done}, 32'd1);
    @(negedge clk);
    check("R8 done ends", {30'd0, hst_done, hst_ready}, 32'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule